// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a synchronous four-beat burst memory access. An external address is captured by one of two address strobes: a processor-side strobe that counts only while the chip enable is high, and a controller-side strobe that needs no enable. The captured address is the first beat of the burst. While the advance input is held high, the two least significant address bits then step through the remaining beats. The bits above them keep their loaded value.

The beat order is chosen by a static mode pin. The order is linear (start plus beat index, wrapping modulo four) when the pin is driven high. It is interleaved (start XOR beat index) when the pin is low or left undriven. A new address can be loaded on any cycle, including the cycle right after another load, so back-to-back bursts cost no idle cycle. Every input except the mode pin is sampled on the rising clock edge. The address and beat index are registered state, so a load or step becomes visible after the edge that captures it.

Top module: `bseq_top`

## Requirements
- R1: While reset is asserted and after it is released, with no load yet, addr_out is 0 and beat is 0.
- R2: When strb_cpu and chip_en are both high at a rising edge, addr_out equals the sampled addr_in and beat equals 0 after that edge.
- R3: A high strb_cpu with chip_en low at a rising edge loads nothing. With strb_ctl and adv also low, beat and addr_out keep their previous values.
- R4: A high strb_ctl at a rising edge loads addr_in and clears beat, whatever the level of chip_en.
- R5: When both strobes are high and chip_en is high at the same edge, exactly one load of addr_in takes place, with beat 0. The processor strobe has priority.
- R6: With no load at an edge, a high adv increments beat by one, and a low adv leaves beat and addr_out unchanged.
- R7: In interleaved order, addr_out[1:0] equals the loaded low bits XOR beat.
- R8: In linear order, addr_out[1:0] equals (loaded low bits + beat) modulo 4.
- R9: An advance from beat 3 wraps beat to 0, and addr_out returns to the loaded address.
- R10: addr_out[ADDR_W-1:2] stays equal to the loaded upper bits until the next load.
- R11: lin_sel driven to 1 selects linear order. A value of 0, or an undriven pin, selects interleaved order.
- R12: Loads on consecutive edges each take effect, with no idle cycle between them.
- R13: adv has no effect at an edge where a load takes place. After that edge, beat is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External start address |
| strb_cpu | input | 1 | Processor-side address strobe, qualified by chip_en |
| strb_ctl | input | 1 | Controller-side address strobe, unqualified |
| chip_en | input | 1 | Enable for the processor strobe |
| adv | input | 1 | Step to the next beat |
| lin_sel | input | 1 | Order select: 1 linear, 0 or undriven interleaved |
| addr_out | output | ADDR_W | Current burst word address |
| beat | output | 2 | Index of the current beat within the burst |

## Verification
On every cycle the assertions check how the strobes capture the address and clear the beat, including the enable qualification, the priority between strobes and whether advance is ignored during a load. They also check the increment, hold and wrap of the beat and that the upper address bits stay fixed. The exact low-bit sequence of each order, and its dependence on the mode pin (including an undriven pin), can only be shown by the bench's scenarios. The bench walks both orders from every start offset and compares each cycle against its own table.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int BEAT_W = 2;
  localparam int BEATS  = 1 << BEAT_W;

  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } order_e;

  // Low address bits of beat n for a burst that starts at offset start.
  function automatic logic [BEAT_W-1:0] beat_offset(input order_e ord,
                                                    input logic [BEAT_W-1:0] start,
                                                    input logic [BEAT_W-1:0] n);
    logic [BEAT_W-1:0] r;
    if (ord == ORD_LINEAR) r = start + n;   // wraps modulo BEATS
    else                   r = start ^ n;
    return r;
  endfunction

  function automatic logic [BEAT_W-1:0] beat_next(input logic [BEAT_W-1:0] b);
    return b + 1'b1;
  endfunction
endpackage

// File: rtl/bseq_load_arb.sv
module bseq_load_arb (
  input  logic strb_cpu,
  input  logic strb_ctl,
  input  logic chip_en,
  input  logic adv,
  output logic load_cpu,
  output logic load_ctl,
  output logic load_any,
  output logic step
);
  always_comb begin
    load_cpu = strb_cpu & chip_en;
    load_ctl = strb_ctl & ~load_cpu;
    load_any = load_cpu | load_ctl;
    step     = adv & ~load_any;
  end
endmodule

// File: rtl/bseq_state.sv
module bseq_state #(
  parameter int ADDR_W = 19
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic                        step,
  input  logic [ADDR_W-1:0]           addr_in,
  output logic [ADDR_W-1:0]           base_q,
  output logic [bseq_pkg::BEAT_W-1:0] beat_q
);
  import bseq_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (step) begin
      beat_q <= beat_next(beat_q);
    end
  end
endmodule

// File: rtl/bseq_addr_map.sv
module bseq_addr_map #(
  parameter int ADDR_W = 19
) (
  input  logic [ADDR_W-1:0]           base,
  input  logic [bseq_pkg::BEAT_W-1:0] beat,
  input  bseq_pkg::order_e            ord,
  output logic [ADDR_W-1:0]           addr_out
);
  import bseq_pkg::*;
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [BEAT_W-1:0] low;
  assign low = beat_offset(ord, base[BEAT_W-1:0], beat);

  genvar i;
  generate
    for (i = 0; i < ADDR_W; i++) begin : g_bit
      if (i < BEAT_W) begin : g_low
        assign addr_out[i] = low[i];
      end else begin : g_high
        assign addr_out[i] = base[i];
      end
    end
  endgenerate

  initial begin
    if (HI_W < 1) $display("bseq_addr_map: ADDR_W must exceed the beat width");
  end
endmodule

// File: rtl/bseq_top.sv
module bseq_top #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strb_cpu,
  input  logic              strb_ctl,
  input  logic              chip_en,
  input  logic              adv,
  input  logic              lin_sel,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat
);
  import bseq_pkg::*;

  logic load_cpu, load_ctl, load_any, step;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  order_e ord;

  // Only a firm high selects linear; low or undriven gives interleaved.
  assign ord = (lin_sel === 1'b1) ? ORD_LINEAR : ORD_INTERLEAVE;

  bseq_load_arb u_arb (
    .strb_cpu (strb_cpu),
    .strb_ctl (strb_ctl),
    .chip_en  (chip_en),
    .adv      (adv),
    .load_cpu (load_cpu),
    .load_ctl (load_ctl),
    .load_any (load_any),
    .step     (step)
  );

  bseq_state #(.ADDR_W(ADDR_W)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_any),
    .step    (step),
    .addr_in (addr_in),
    .base_q  (base_q),
    .beat_q  (beat_q)
  );

  bseq_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .base     (base_q),
    .beat     (beat_q),
    .ord      (ord),
    .addr_out (addr_out)
  );

  assign beat = beat_q;
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              strb_cpu,
  input logic              strb_ctl,
  input logic              chip_en,
  input logic              adv,
  input logic [ADDR_W-1:0] addr_out,
  input logic [1:0]        beat,
  input logic              load_cpu,
  input logic              load_ctl,
  input logic              step
);
  assert_cpu_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_cpu && chip_en) |=> (beat == 2'd0 && addr_out == $past(addr_in)));

  assert_cpu_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_cpu && !chip_en && !strb_ctl && !adv) |=> ($stable(beat) && $stable(addr_out[ADDR_W-1:2])));

  assert_ctl_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb_ctl |=> (beat == 2'd0 && addr_out == $past(addr_in)));

  assert_single_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_cpu, load_ctl}));

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !strb_ctl && !(strb_cpu && chip_en)) |=> (beat == $past(beat) + 2'd1));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !strb_ctl && !(strb_cpu && chip_en)) |=> $stable(beat));

  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && beat == 2'd3) |=> (beat == 2'd0));

  assert_upper_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_ctl && !(strb_cpu && chip_en)) |=> $stable(addr_out[ADDR_W-1:2]));

  assert_adv_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((strb_ctl || (strb_cpu && chip_en)) && adv) |=> (beat == 2'd0));
endmodule

bind bseq_top bseq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr_in  (addr_in),
  .strb_cpu (strb_cpu),
  .strb_ctl (strb_ctl),
  .chip_en  (chip_en),
  .adv      (adv),
  .addr_out (addr_out),
  .beat     (beat),
  .load_cpu (load_cpu),
  .load_ctl (load_ctl),
  .step     (step)
);

// File: tb/bseq_top_tb.sv
module bseq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 19;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] addr_in;
  logic              strb_cpu, strb_ctl, chip_en, adv, lin_sel;
  logic [ADDR_W-1:0] addr_out;
  logic [1:0]        beat;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  int tbl [2][4][4];   // [linear][start][beat] -> low bits
  int m_base = 0;
  int m_beat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bseq_top #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strb_cpu(strb_cpu),
    .strb_ctl(strb_ctl), .chip_en(chip_en), .adv(adv), .lin_sel(lin_sel),
    .addr_out(addr_out), .beat(beat)
  );

  task automatic check(input string tag);
    int lin, exp_addr;
    lin = (lin_sel === 1'b1) ? 1 : 0;
    exp_addr = (m_base / 4) * 4 + tbl[lin][m_base % 4][m_beat];
    n_tests++;
    if (addr_out !== exp_addr[ADDR_W-1:0] || beat !== m_beat[1:0]) begin
      n_fail++;
      $display("FAIL %s: addr=%0h beat=%0d expected addr=%0h beat=%0d",
               tag, addr_out, beat, exp_addr, m_beat);
    end
  endtask

  task automatic step(input int a, input bit cpu, input bit ctl, input bit ce,
                      input bit ad, input string tag);
    addr_in = a[ADDR_W-1:0]; strb_cpu = cpu; strb_ctl = ctl; chip_en = ce; adv = ad;
    @(posedge clk);
    if (cpu && ce)      begin m_base = a; m_beat = 0; end
    else if (ctl)       begin m_base = a; m_beat = 0; end
    else if (ad)        m_beat = (m_beat + 1) % 4;
    @(negedge clk);
    check(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 4; s++)
      for (int n = 0; n < 4; n++) begin
        tbl[1][s][n] = (s + n) % 4;
        tbl[0][s][n] = (((s / 2) != (n / 2)) ? 2 : 0) + (((s % 2) != (n % 2)) ? 1 : 0);
      end

    rst_n = 1'b0; addr_in = '0; strb_cpu = 0; strb_ctl = 0; chip_en = 0; adv = 0; lin_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); check("R1 in reset");
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, "R1 after reset");

    // Both orders, every start offset, full burst plus wrap and hold (R7 R8 R9 R10 R6)
    for (int lin = 0; lin < 2; lin++)
      for (int s = 0; s < 4; s++) begin
        lin_sel = lin[0];
        step((((s * 37 + lin * 11 + 5) % 4096) * 4) + s, 1, 0, 1, 0,
             "R2 processor load");
        for (int n = 1; n < 4; n++) step(0, 0, 0, 0, 1, lin ? "R8 linear beat" : "R7 interleaved beat");
        step(0, 0, 0, 0, 1, "R9 wrap to start");
        step(0, 0, 0, 0, 0, "R6 hold without advance");
        step(0, 0, 0, 0, 1, "R10 upper bits fixed");
      end

    // Processor strobe with chip disabled is ignored (R3)
    lin_sel = 1;
    step(32'h1_2345, 0, 1, 0, 0, "R4 controller load without enable");
    step(32'h7_0000, 1, 0, 0, 0, "R3 gated processor strobe");
    step(32'h7_0000, 1, 0, 0, 1, "R3 gated strobe, advance only");
    step(0, 0, 0, 0, 1, "R4 controller burst beat");

    // Simultaneous strobes with advance (R5 R13)
    step(32'h2_AAAB, 1, 1, 1, 1, "R5 both strobes, R13 advance ignored");
    step(0, 0, 0, 0, 1, "R5 burst after dual strobe");
    step(32'h3_0002, 0, 1, 1, 1, "R13 controller load with advance");

    // Back-to-back loads (R12)
    step(32'h0_1001, 1, 0, 1, 0, "R12 first load");
    step(32'h4_5556, 0, 1, 0, 0, "R12 second load next cycle");
    step(32'h6_0003, 1, 0, 1, 1, "R12 third load next cycle");
    step(0, 0, 0, 0, 1, "R12 burst after loads");

    // Mode pin undriven selects interleaved (R11)
    lin_sel = 1'bz;
    step(32'h5_0001, 1, 0, 1, 0, "R11 undriven mode load");
    for (int n = 1; n < 4; n++) step(0, 0, 0, 0, 1, "R11 undriven mode beat");
    lin_sel = 1'b1;
    step(32'h5_0001, 1, 0, 1, 0, "R11 driven linear load");
    step(0, 0, 0, 0, 1, "R11 driven linear beat");

    finish_run();
  end
endmodule